// File: doc/BRIEF.md
# I2C Slave Shutdown Sequencer

This block sits beside an I2C slave engine and decides when a software request to switch the slave off may take effect. Software drives a single enable bit. Setting that bit turns the slave on at the next clock. Clearing it only opens a pending window. The effective enable stays high until the bus reaches a point where stopping is safe: a byte acknowledge point, a STOP condition or an idle bus. While the window is open and the slave is being addressed or written to, the block asks the engine to NACK.

During the pending window the block records two abort causes as sticky flags. The first says that a slave transfer was cut short while it was active. The second says that bytes received from the remote master were discarded. Software reads the effective enable and both flags through a 32-bit read-only status word. Software should trust the two flags only after the enable bit of that word has dropped to 0. Setting the software enable again clears both flags.

The engine reports the bus phase through abstract indicators. The `dir_tx` input selects the direction: 1 means the slave transmits (the remote master reads), 0 means the slave receives.

Top module: `i2c_slv_shutdown_ctrl`

## Requirements
- R1: While reset is held, and at the first cycle after it, `en_eff`, `force_nack` and every bit of `status_word` read 0.
- R2: After a rising clock edge at which `sw_enable` is 1, `en_eff` is 1. `status_word[0]` equals `en_eff` at all times. While `sw_enable` is 1, `status_word[2:1]` read 0.
- R3: When `sw_enable` is 0 and `en_eff` is 1 (pending), `en_eff` stays 1 across any edge at which none of `byte_done`, `stop_seen` or `bus_idle` is 1.
- R4: When pending and any of `byte_done`, `stop_seen` or `bus_idle` is 1 at an edge, `en_eff` is 0 after that edge.
- R5: `force_nack` is 1 exactly when the block is pending and either `ph_addr` is 1, or `ph_data` is 1 with `dir_tx`=0 and `addr_hit`=1.
- R6: `status_word[1]` (busy-abort) is set by an edge at which the block is pending and `ph_addr` is 1, whatever the values of `addr_hit` and `dir_tx`. It is also set by a pending edge during a matched receive data phase.
- R7: `status_word[2]` (rx-lost) is set by a pending edge in either of two cases. Case one: a matched receive byte completes (`ph_data`=1, `dir_tx`=0, `addr_hit`=1, `byte_done`=1). Case two: a byte has already completed in the current receive transfer and that transfer is still in its data phase or ends with `stop_seen`. The record of a received byte is cleared by `ph_addr`, `stop_seen` or `bus_idle`.
- R8: Both flags stay 0 when the disable completes while the bus is idle, during a transmit data phase, or during a data phase without an address match.
- R9: Both flags clear after an edge with `sw_enable`=1. They hold their value while the block is neither enabled by software nor pending.
- R10: `status_word[31:3]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_enable | input | 1 | Software enable request |
| ph_addr | input | 1 | Engine is receiving an address byte |
| ph_data | input | 1 | Engine is in a data phase |
| dir_tx | input | 1 | 1 = slave transmit, 0 = slave receive |
| addr_hit | input | 1 | Received address matched this slave |
| byte_done | input | 1 | A byte reached its acknowledge point this cycle |
| stop_seen | input | 1 | STOP condition detected this cycle |
| bus_idle | input | 1 | Bus is idle |
| en_eff | output | 1 | Effective enable |
| force_nack | output | 1 | Request to NACK the current byte |
| status_word | output | 32 | {29'b0, rx_lost, busy_abort, en_eff} |

## Verification
The bench goes after several timing corners. One is an enable that is cleared while a matched receive is mid-byte. A design that completed the disable early there would drop `en_eff` before the acknowledge point and lose data without recording it. Another is a STOP that arrives after one received byte but before any NACK. A design that kept no record of the earlier byte would leave rx-lost at 0 in that case. Further corners are an unmatched address, where busy-abort must still be set, and a transmit or unmatched data phase, where both flags must stay 0. The last is re-enabling, which must clear the flags and mask them at once, while the flags must hold steady once the block is off.

// File: rtl/i2c_shdn_pkg.sv
package i2c_shdn_pkg;

  typedef struct packed {
    logic rx_lost;
    logic busy_abort;
  } abort_t;

  // Slave is engaged: any address byte, or a matched receive data phase.
  function automatic logic f_slave_busy(input logic addr_ph, input logic data_ph,
                                        input logic tx, input logic hit);
    return addr_ph | (data_ph & ~tx & hit);
  endfunction

  // Matched receive data phase.
  function automatic logic f_rx_active(input logic data_ph, input logic tx,
                                       input logic hit);
    return data_ph & ~tx & hit;
  endfunction

  // Points at which a pending disable may complete.
  function automatic logic f_disable_ok(input logic bdone, input logic stop,
                                        input logic idle);
    return bdone | stop | idle;
  endfunction

endpackage

// File: rtl/shdn_phase_track.sv
module shdn_phase_track
  import i2c_shdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ph_addr,
  input  logic ph_data,
  input  logic dir_tx,
  input  logic addr_hit,
  input  logic byte_done,
  input  logic stop_seen,
  input  logic bus_idle,
  output logic slave_busy,
  output logic rx_active,
  output logic rx_byte_in,
  output logic rx_seen
);

  logic xfer_reset;

  assign slave_busy = f_slave_busy(ph_addr, ph_data, dir_tx, addr_hit);
  assign rx_active  = f_rx_active(ph_data, dir_tx, addr_hit);
  assign rx_byte_in = rx_active & byte_done;
  assign xfer_reset = ph_addr | stop_seen | bus_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_seen <= 1'b0;
    else if (rx_byte_in) rx_seen <= 1'b1;
    else if (xfer_reset) rx_seen <= 1'b0;
  end

  assert_seen_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_in |=> rx_seen);
  assert_seen_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_reset && !rx_byte_in) |=> !rx_seen);

endmodule

// File: rtl/shdn_enable_ctrl.sv
module shdn_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_enable,
  input  logic complete_ok,
  output logic en_eff,
  output logic pending
);

  logic finish_evt;

  assign pending    = en_eff & ~sw_enable;
  assign finish_evt = pending & complete_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_eff <= 1'b0;
    else if (sw_enable)  en_eff <= 1'b1;
    else if (finish_evt) en_eff <= 1'b0;
  end

  assert_enable_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_enable |=> en_eff);
  assert_pending_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !complete_ok) |=> en_eff);
  assert_disable_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && complete_ok) |=> !en_eff);

endmodule

// File: rtl/shdn_abort_flags.sv
module shdn_abort_flags
  import i2c_shdn_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_enable,
  input  logic   pending,
  input  logic   slave_busy,
  input  logic   rx_active,
  input  logic   rx_byte_in,
  input  logic   rx_seen,
  input  logic   stop_seen,
  output abort_t flags
);

  logic busy_hit;
  logic lost_hit;

  assign busy_hit = pending & slave_busy;
  assign lost_hit = pending & (rx_byte_in | (rx_seen & (rx_active | stop_seen)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (sw_enable) begin
      flags <= '0;
    end else begin
      if (busy_hit) flags.busy_abort <= 1'b1;
      if (lost_hit) flags.rx_lost    <= 1'b1;
    end
  end

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_enable |=> (flags == '0));
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_enable && !pending) |=> $stable(flags));
  assert_busy_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> flags.busy_abort);
  assert_lost_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_hit |=> flags.rx_lost);

endmodule

// File: rtl/i2c_slv_shutdown_ctrl.sv
module i2c_slv_shutdown_ctrl
  import i2c_shdn_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_enable,
  input  logic                ph_addr,
  input  logic                ph_data,
  input  logic                dir_tx,
  input  logic                addr_hit,
  input  logic                byte_done,
  input  logic                stop_seen,
  input  logic                bus_idle,
  output logic                en_eff,
  output logic                force_nack,
  output logic [STATUS_W-1:0] status_word
);

  localparam int PAD_W = STATUS_W - 3;

  logic   slave_busy;
  logic   rx_active;
  logic   rx_byte_in;
  logic   rx_seen;
  logic   pending;
  logic   complete_ok;
  abort_t flags;
  abort_t flags_vis;

  assign complete_ok = f_disable_ok(byte_done, stop_seen, bus_idle);

  shdn_phase_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_addr    (ph_addr),
    .ph_data    (ph_data),
    .dir_tx     (dir_tx),
    .addr_hit   (addr_hit),
    .byte_done  (byte_done),
    .stop_seen  (stop_seen),
    .bus_idle   (bus_idle),
    .slave_busy (slave_busy),
    .rx_active  (rx_active),
    .rx_byte_in (rx_byte_in),
    .rx_seen    (rx_seen)
  );

  shdn_enable_ctrl u_enable (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_enable   (sw_enable),
    .complete_ok (complete_ok),
    .en_eff      (en_eff),
    .pending     (pending)
  );

  shdn_abort_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_enable  (sw_enable),
    .pending    (pending),
    .slave_busy (slave_busy),
    .rx_active  (rx_active),
    .rx_byte_in (rx_byte_in),
    .rx_seen    (rx_seen),
    .stop_seen  (stop_seen),
    .flags      (flags)
  );

  assign force_nack = pending & slave_busy;
  assign flags_vis  = sw_enable ? '0 : flags;

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_word = {{PAD_W{1'b0}}, flags_vis.rx_lost, flags_vis.busy_abort, en_eff};
    end else begin : g_nopad
      assign status_word = {flags_vis.rx_lost, flags_vis.busy_abort, en_eff};
    end
  endgenerate

  assert_nack_only_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_nack |-> (en_eff && !sw_enable));
  assert_masked_when_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_enable |-> (status_word[2:1] == 2'b00));

endmodule

// File: tb/i2c_slv_shutdown_ctrl_bench.sv
module i2c_slv_shutdown_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_enable = 1'b0, ph_addr = 1'b0, ph_data = 1'b0, dir_tx = 1'b0;
  logic        addr_hit = 1'b0, byte_done = 1'b0, stop_seen = 1'b0, bus_idle = 1'b0;
  logic        en_eff, force_nack;
  logic [31:0] status_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Bench model state
  logic m_en = 1'b0, m_busy = 1'b0, m_lost = 1'b0, m_seen = 1'b0;

  always #5 clk = ~clk;

  i2c_slv_shutdown_ctrl u_i2c_slv_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .ph_addr(ph_addr),
    .ph_data(ph_data), .dir_tx(dir_tx), .addr_hit(addr_hit), .byte_done(byte_done),
    .stop_seen(stop_seen), .bus_idle(bus_idle), .en_eff(en_eff),
    .force_nack(force_nack), .status_word(status_word)
  );

  function automatic logic exp_nack(logic en, logic se, logic pa, logic pd, logic dt, logic ah);
    return en && !se && (pa || (pd && !dt && ah));
  endfunction

  function automatic logic [31:0] exp_status(logic en, logic bsy, logic lst, logic se);
    logic [31:0] w;
    w = '0;
    w[0] = en;
    w[1] = bsy && !se;
    w[2] = lst && !se;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic pend, rxb, bin;
    pend = m_en && !sw_enable;
    rxb  = ph_data && !dir_tx && addr_hit;
    bin  = rxb && byte_done;
    if (sw_enable) begin
      m_busy = 1'b0; m_lost = 1'b0;
    end else if (pend) begin
      if (ph_addr || rxb) m_busy = 1'b1;
      if (bin || (m_seen && (rxb || stop_seen))) m_lost = 1'b1;
    end
    if (bin) m_seen = 1'b1;
    else if (stop_seen || bus_idle || ph_addr) m_seen = 1'b0;
    if (sw_enable) m_en = 1'b1;
    else if (pend && (byte_done || stop_seen || bus_idle)) m_en = 1'b0;
  endtask

  // One cycle: drive, compare combinational and registered outputs, advance the model.
  task automatic step(string tag, logic se, logic pa, logic pd, logic dt, logic ah,
                      logic bd, logic sp, logic bi);
    @(negedge clk);
    sw_enable = se; ph_addr = pa; ph_data = pd; dir_tx = dt;
    addr_hit = ah; byte_done = bd; stop_seen = sp; bus_idle = bi;
    #1;
    chk({tag, " status"}, status_word, exp_status(m_en, m_busy, m_lost, se));
    chk({tag, " en_eff"}, {31'b0, en_eff}, {31'b0, m_en});
    chk({tag, " force_nack"}, {31'b0, force_nack},
        {31'b0, exp_nack(m_en, se, pa, pd, dt, ah)});
    @(posedge clk);
    model_update();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", status_word, 32'h0);
    chk("R1 reset outputs", {30'b0, en_eff, force_nack}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0);

    // Enable; then disable while bus idle: no flags (R8)
    step("R2 enable", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R2 enabled", 1, 1, 0, 0, 1, 0, 0, 0);
    step("R8 idle disable", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8 idle off", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 idle flags", status_word, 32'h0);

    // Pending across a matched receive, completes at byte ack (R3,R4,R5,R6,R7)
    step("R2 re-enable", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3 pending addr", 0, 1, 0, 0, 1, 0, 0, 0);
    step("R5 pending data", 0, 0, 1, 0, 1, 0, 0, 0);
    step("R4 byte ack", 0, 0, 1, 0, 1, 1, 0, 0);
    step("R4 off", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 R7 flags", status_word, 32'h6);
    step("R9 hold", 0, 1, 1, 0, 1, 1, 1, 0);
    chk("R9 flags hold", status_word, 32'h6);

    // Re-enable clears flags and masks at once (R9)
    step("R9 reenable mask", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R9 cleared", 1, 0, 0, 0, 0, 0, 0, 0);

    // Unmatched address sets busy only (R6)
    step("R6 unmatched addr", 0, 1, 0, 1, 0, 0, 0, 0);
    step("R6 ack", 0, 1, 0, 1, 0, 1, 0, 0);
    step("R6 off", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 busy only", status_word, 32'h2);

    // Byte received while enabled, then STOP before NACK while pending (R7)
    step("R7 enable", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R7 addr", 1, 1, 0, 0, 1, 0, 0, 0);
    step("R7 byte", 1, 0, 1, 0, 1, 1, 0, 0);
    step("R7 stop", 0, 0, 0, 0, 1, 0, 1, 0);
    step("R7 off", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 stop lost", status_word, 32'h4);

    // Transmit data phase and unmatched data phase: no flags (R8)
    step("R8 enable", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R8 tx data", 0, 0, 1, 1, 1, 0, 0, 0);
    step("R8 unmatched data", 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8 tx ack", 0, 0, 1, 1, 1, 1, 0, 0);
    step("R8 off", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 master-only flags", status_word, 32'h0);
    chk("R10 upper bits", {3'b0, status_word[31:3]}, 32'h0);

    // Constrained random
    begin
      logic se;
      se = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 8) == 0) se = ~se;
        step("R2-R10 random", se, ($urandom % 4) == 0, ($urandom % 3) == 0,
             ($urandom % 2) == 0, ($urandom % 3) != 0, ($urandom % 6) == 0,
             ($urandom % 10) == 0, ($urandom % 8) == 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule